// File: doc/BRIEF.md
# Float to Integer Converter

This block turns an IEEE single-precision word into a 32-bit integer, either unsigned or two's-complement signed, chosen per request by a mode input. The fractional part is resolved by one of four rounding modes, or always discarded when the truncate control is set. Alongside the integer it reports three flags: invalid (the value cannot be represented or was a NaN), inexact (a nonzero fraction was dropped) and input-denormal (the operand was subnormal).

A request is presented with a one-cycle `in_valid` strobe. The result and flags appear registered one clock later with `out_valid`, and stay put until the next request. Out-of-range operands saturate to mode-specific limits rather than wrapping, and magnitudes below one half are handled on a short path that honours the directed rounding modes.

Top module: `f2i_conv`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0 and `out_int`, `out_invalid`, `out_inexact`, `out_denorm` are all 0 until the first request.
- R2: A request with `in_valid`=1 produces `out_valid`=1 one clock later; when `in_valid`=0 the outputs keep their previous values and `out_valid` is 0 the next cycle.
- R3: For biased exponents 126 to 158 the value is rounded per `rnd_mode`: 0 nearest with ties to even, 1 toward +infinity, 2 toward -infinity, 3 toward zero; a nonzero discarded fraction sets `out_inexact`.
- R4: With `trunc`=1 the `rnd_mode` input has no effect and rounding is toward zero.
- R5: A NaN operand (exponent 255, nonzero fraction) gives 0xFFFFFFFF in unsigned mode and 0 in signed mode, always with `out_invalid`.
- R6: A biased exponent of 159 or more (including infinities) saturates: unsigned gives 0xFFFFFFFF for positive and 0 for negative; signed gives 0x7FFFFFFF for positive and 0x80000000 for negative; `out_invalid` is set.
- R7: In signed mode a rounded magnitude above 0x7FFFFFFF (positive) or 0x80000000 (negative) is clamped to that limit with `out_invalid` and no `out_inexact`; otherwise the negative result is the two's complement of the magnitude.
- R8: In unsigned mode a negative operand whose rounded magnitude is nonzero gives 0 with `out_invalid`; a rounded magnitude of 0 gives 0 with only `out_inexact`.
- R9: Below exponent 126 a nonzero operand gives 0 with `out_inexact`, except toward +infinity on a positive value gives 1, and toward -infinity on a negative value gives 0xFFFFFFFF (signed) or 0 with `out_invalid` (unsigned).
- R10: A subnormal operand (exponent 0, nonzero fraction) sets `out_denorm` in addition to the small-magnitude result.
- R11: A zero operand of either sign gives 0 with all flags clear.
- `in_data` bit 31 is the sign, bits 30:23 the biased exponent, bits 22:0 the fraction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_data | input | 32 | Single-precision operand |
| is_signed | input | 1 | 1 = signed result, 0 = unsigned |
| rnd_mode | input | 2 | Rounding mode (0 nearest, 1 +inf, 2 -inf, 3 zero) |
| trunc | input | 1 | Force rounding toward zero |
| out_valid | output | 1 | Result strobe, one clock after request |
| out_int | output | 32 | Integer result |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |
| out_denorm | output | 1 | Subnormal-input flag |

## Verification
Halfway values such as 2.5 and 3.5 separate ties-to-even from plain round-half-up, and the same operands under the directed modes with both signs tell the +inf and -inf increments apart from truncation. Powers of two at exponents 158 and 159 expose the asymmetric signed limits and the boundary between clamping and out-of-range saturation. Quarter-valued and subnormal operands drive the small-magnitude path in every directed mode, where signed and unsigned diverge into -1 versus 0 with invalid, and NaN in both modes shows the mode-specific NaN result.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int INT_W = 32;

  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_POS  = 2'd1,
    RND_NEG  = 2'd2,
    RND_ZERO = 2'd3
  } rnd_e;

  typedef enum logic [1:0] {
    SPAN_SMALL = 2'd0,
    SPAN_RANGE = 2'd1,
    SPAN_HUGE  = 2'd2
  } span_e;
endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack #(
  parameter int EW = 8,
  parameter int MW = 23
) (
  input  logic [EW+MW:0] word_i,
  output logic           sign_o,
  output logic [EW-1:0]  exp_o,
  output logic [MW-1:0]  man_o,
  output logic           nan_o,
  output logic           zero_o,
  output logic           denorm_o
);
  logic exp_ones, exp_zero, man_nz;

  always_comb begin
    sign_o   = word_i[EW+MW];
    exp_o    = word_i[EW+MW-1:MW];
    man_o    = word_i[MW-1:0];
    exp_ones = &exp_o;
    exp_zero = ~|exp_o;
    man_nz   = |man_o;
    nan_o    = exp_ones & man_nz;
    zero_o   = exp_zero & ~man_nz;
    denorm_o = exp_zero & man_nz;
  end
endmodule

// File: rtl/f2i_align.sv
module f2i_align
  import f2i_pkg::*;
#(
  parameter int EW = 8,
  parameter int MW = 23,
  parameter int IW = 32
) (
  input  logic [EW-1:0] exp_i,
  input  logic [MW-1:0] man_i,
  output logic [IW-1:0] ipart_o,
  output logic [IW-1:0] rem_o,
  output span_e         span_o
);
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int HI   = BIAS + IW - 1;
  localparam int LO   = BIAS - 1;
  localparam int SW   = $clog2(IW + 1);
  localparam int PADW = IW - 1 - MW;

  logic [IW-1:0]   mant;
  logic [SW-1:0]   shamt;
  logic [2*IW-1:0] wide;

  always_comb begin
    mant = {1'b1, man_i, {PADW{1'b0}}};
    if (int'(exp_i) > HI) begin
      span_o = SPAN_HUGE;
      shamt  = '0;
    end else if (int'(exp_i) >= LO) begin
      span_o = SPAN_RANGE;
      shamt  = SW'(HI - int'(exp_i));
    end else begin
      span_o = SPAN_SMALL;
      shamt  = '0;
    end
    wide    = {mant, {IW{1'b0}}} >> shamt;
    ipart_o = wide[2*IW-1:IW];
    rem_o   = wide[IW-1:0];
  end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import f2i_pkg::*;
#(
  parameter int IW = 32
) (
  input  logic [IW-1:0] ipart_i,
  input  logic [IW-1:0] rem_i,
  input  logic          sign_i,
  input  logic          signed_i,
  input  rnd_e          mode_i,
  output logic [IW-1:0] value_o,
  output logic          invalid_o,
  output logic          inexact_o
);
  logic [IW-1:0] incr, bumped, limit;
  logic [IW:0]   sum;
  logic          carry, at_max, frac_nz;

  always_comb begin
    unique case (mode_i)
      RND_NEAR: incr = {1'b1, {(IW-1){1'b0}}} - {{(IW-1){1'b0}}, ~ipart_i[0]};
      RND_POS:  incr = sign_i ? '0 : '1;
      RND_NEG:  incr = sign_i ? '1 : '0;
      default:  incr = '0;
    endcase
    sum     = {1'b0, rem_i} + {1'b0, incr};
    carry   = sum[IW];
    at_max  = &ipart_i;
    frac_nz = |rem_i;
    bumped  = (carry && !at_max) ? ipart_i + 1'b1 : ipart_i;
    limit   = sign_i ? {1'b1, {(IW-1){1'b0}}} : {1'b0, {(IW-1){1'b1}}};

    value_o   = '0;
    invalid_o = 1'b0;
    inexact_o = 1'b0;
    if (signed_i) begin
      if (bumped > limit) begin
        value_o   = sign_i ? limit : limit;
        invalid_o = 1'b1;
      end else begin
        value_o   = bumped;
        inexact_o = frac_nz;
      end
      if (sign_i) value_o = -value_o;
    end else begin
      invalid_o = carry && at_max;
      if (sign_i && (bumped != '0)) begin
        value_o   = '0;
        invalid_o = 1'b1;
      end else begin
        value_o   = bumped;
        inexact_o = frac_nz;
      end
    end
  end
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
  import f2i_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W,
  parameter int IW = INT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [EW+MW:0]   in_data,
  input  logic             is_signed,
  input  logic [1:0]       rnd_mode,
  input  logic             trunc,
  output logic             out_valid,
  output logic [IW-1:0]    out_int,
  output logic             out_invalid,
  output logic             out_inexact,
  output logic             out_denorm
);
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic          op_sign, op_nan, op_zero, op_denorm;
  logic [EW-1:0] op_exp;
  logic [MW-1:0] op_man;
  logic [IW-1:0] ipart, rem, rnd_value;
  logic          rnd_invalid, rnd_inexact;
  span_e         span;
  rnd_e          mode_eff;

  assign mode_eff = trunc ? RND_ZERO : rnd_e'(rnd_mode);

  f2i_unpack #(.EW(EW), .MW(MW)) u_unpack (
    .word_i(in_data), .sign_o(op_sign), .exp_o(op_exp), .man_o(op_man),
    .nan_o(op_nan), .zero_o(op_zero), .denorm_o(op_denorm)
  );

  f2i_align #(.EW(EW), .MW(MW), .IW(IW)) u_align (
    .exp_i(op_exp), .man_i(op_man), .ipart_o(ipart), .rem_o(rem), .span_o(span)
  );

  f2i_round #(.IW(IW)) u_round (
    .ipart_i(ipart), .rem_i(rem), .sign_i(op_sign), .signed_i(is_signed),
    .mode_i(mode_eff), .value_o(rnd_value), .invalid_o(rnd_invalid),
    .inexact_o(rnd_inexact)
  );

  logic [IW-1:0] int_d, int_q;
  logic          inv_d, inv_q, inx_d, inx_q, den_d, den_q, vld_d, vld_q;
  logic          load;

  always_comb begin
    inv_d = 1'b0;
    inx_d = 1'b0;
    den_d = op_denorm;
    if (op_nan) begin
      int_d = is_signed ? '0 : '1;
      inv_d = 1'b1;
    end else if (span == SPAN_HUGE) begin
      if (is_signed) int_d = op_sign ? {1'b1, {(IW-1){1'b0}}} : {1'b0, {(IW-1){1'b1}}};
      else           int_d = op_sign ? '0 : '1;
      inv_d = 1'b1;
    end else if (span == SPAN_RANGE) begin
      int_d = rnd_value;
      inv_d = rnd_invalid;
      inx_d = rnd_inexact;
    end else begin
      int_d = '0;
      if (!op_zero) begin
        inx_d = 1'b1;
        if (mode_eff == RND_POS && !op_sign) begin
          int_d = {{(IW-1){1'b0}}, 1'b1};
        end else if (mode_eff == RND_NEG && op_sign) begin
          if (is_signed) int_d = '1;
          else           inv_d = 1'b1;
        end
      end
    end
  end

  assign load  = in_valid;
  assign vld_d = in_valid;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q <= 1'b0;
      int_q <= '0;
      inv_q <= 1'b0;
      inx_q <= 1'b0;
      den_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (load) begin
        int_q <= int_d;
        inv_q <= inv_d;
        inx_q <= inx_d;
        den_q <= den_d;
      end
    end
  end

  assign out_valid   = vld_q;
  assign out_int     = int_q;
  assign out_invalid = inv_q;
  assign out_inexact = inx_q;
  assign out_denorm  = den_q;
endmodule

// File: rtl/f2i_conv_chk.sv
module f2i_conv_chk #(
  parameter int EW = 8,
  parameter int MW = 23,
  parameter int IW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [EW+MW:0] in_data,
  input logic           out_valid,
  input logic [IW-1:0]  out_int,
  input logic           out_invalid,
  input logic           out_inexact,
  input logic           out_denorm
);
  localparam logic [IW-1:0] SMAX = {1'b0, {(IW-1){1'b1}}};
  localparam logic [IW-1:0] SMIN = {1'b1, {(IW-1){1'b0}}};

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid) else $error("valid latency"); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_int) && $stable(out_invalid))) else $error("hold"); // R2

  AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data[EW+MW-1:0] == '0) |=>
      (out_int == '0 && !out_invalid && !out_inexact && !out_denorm)) else $error("zero"); // R11

  AST_INVALID_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |->
      (out_int == '0 || out_int == '1 || out_int == SMAX || out_int == SMIN)) else $error("sat"); // R6

  AST_DENORM_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_denorm) |->
      (out_inexact && (out_int == '0 || out_int == IW'(1) || out_int == '1))) else $error("denorm"); // R10
endmodule

bind f2i_conv f2i_conv_chk #(.EW(EW), .MW(MW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_int(out_int), .out_invalid(out_invalid),
  .out_inexact(out_inexact), .out_denorm(out_denorm)
);

// File: tb/sim_f2i_conv.sv
module sim_f2i_conv;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk, rst_n, in_valid, is_signed, trunc;
  logic [31:0] in_data;
  logic [1:0]  rnd_mode;
  logic        out_valid, out_invalid, out_inexact, out_denorm;
  logic [31:0] out_int;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  f2i_conv u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .is_signed(is_signed), .rnd_mode(rnd_mode), .trunc(trunc),
    .out_valid(out_valid), .out_int(out_int), .out_invalid(out_invalid),
    .out_inexact(out_inexact), .out_denorm(out_denorm)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // flags are {invalid, inexact, denorm}
  task automatic check(input string tag, input logic [31:0] act_i, input logic [31:0] exp_i,
                       input logic [2:0] act_f, input logic [2:0] exp_f);
    total++;
    if (act_i !== exp_i || act_f !== exp_f) begin
      bad++;
      $display("FAIL %s: actual int=%08h flags=%03b expected int=%08h flags=%03b",
               tag, act_i, act_f, exp_i, exp_f);
    end
  endtask

  // drive at negedge, sample at the following negedge (one register stage)
  task automatic conv(input string tag, input logic [31:0] d, input logic sg,
                      input logic [1:0] rm, input logic tr,
                      input logic [31:0] exp_i, input logic [2:0] exp_f);
    in_data = d; is_signed = sg; rnd_mode = rm; trunc = tr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    total++;
    if (out_valid !== 1'b1) begin
      bad++;
      $display("FAIL R2 %s: actual out_valid=%b expected 1", tag, out_valid);
    end
    check(tag, out_int, exp_i, {out_invalid, out_inexact, out_denorm}, exp_f);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; is_signed = 1'b0; rnd_mode = 2'd0; trunc = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 during reset", {31'b0, out_valid}, 32'h0, {out_invalid, out_inexact, out_denorm}, 3'b000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", out_int, 32'h0, {out_invalid, out_inexact, out_denorm}, 3'b000);
    total++;
    if (out_valid !== 1'b0) begin bad++; $display("FAIL R1: actual out_valid=%b expected 0", out_valid); end
  endtask

  task automatic t_nearest;
    conv("R3 1.0 near",   32'h3F800000, 1, 0, 0, 32'h00000001, 3'b000);
    conv("R3 2.5 near",   32'h40200000, 1, 0, 0, 32'h00000002, 3'b010);
    conv("R3 3.5 near",   32'h40600000, 1, 0, 0, 32'h00000004, 3'b010);
    conv("R3 -2.5 near",  32'hC0200000, 1, 0, 0, 32'hFFFFFFFE, 3'b010);
    conv("R3 0.5 near",   32'h3F000000, 0, 0, 0, 32'h00000000, 3'b010);
    conv("R3 0.75 near",  32'h3F400000, 0, 0, 0, 32'h00000001, 3'b010);
    conv("R3 max unsigned", 32'h4F7FFFFF, 0, 0, 0, 32'hFFFFFF00, 3'b000);
  endtask

  task automatic t_directed;
    conv("R3 2.5 +inf",   32'h40200000, 1, 1, 0, 32'h00000003, 3'b010);
    conv("R3 2.5 -inf",   32'h40200000, 1, 2, 0, 32'h00000002, 3'b010);
    conv("R3 -2.5 -inf",  32'hC0200000, 1, 2, 0, 32'hFFFFFFFD, 3'b010);
    conv("R3 -2.5 +inf",  32'hC0200000, 1, 1, 0, 32'hFFFFFFFE, 3'b010);
    conv("R3 3.5 zero",   32'h40600000, 0, 3, 0, 32'h00000003, 3'b010);
  endtask

  task automatic t_trunc;
    conv("R4 2.5 trunc +inf",  32'h40200000, 1, 1, 1, 32'h00000002, 3'b010);
    conv("R4 -2.5 trunc -inf", 32'hC0200000, 1, 2, 1, 32'hFFFFFFFE, 3'b010);
    conv("R4 3.5 trunc near",  32'h40600000, 0, 0, 1, 32'h00000003, 3'b010);
  endtask

  task automatic t_nan;
    conv("R5 nan unsigned", 32'h7FC00000, 0, 0, 0, 32'hFFFFFFFF, 3'b100);
    conv("R5 nan signed",   32'hFFC00001, 1, 0, 0, 32'h00000000, 3'b100);
  endtask

  task automatic t_huge;
    conv("R6 2^32 unsigned",  32'h4F800000, 0, 0, 0, 32'hFFFFFFFF, 3'b100);
    conv("R6 -2^32 unsigned", 32'hCF800000, 0, 0, 0, 32'h00000000, 3'b100);
    conv("R6 2^32 signed",    32'h4F800000, 1, 0, 0, 32'h7FFFFFFF, 3'b100);
    conv("R6 -2^32 signed",   32'hCF800000, 1, 0, 0, 32'h80000000, 3'b100);
    conv("R6 +inf signed",    32'h7F800000, 1, 0, 0, 32'h7FFFFFFF, 3'b100);
  endtask

  task automatic t_clamp;
    conv("R7 2^31 signed",    32'h4F000000, 1, 0, 0, 32'h7FFFFFFF, 3'b100);
    conv("R7 -2^31 signed",   32'hCF000000, 1, 0, 0, 32'h80000000, 3'b000);
    conv("R7 2^31 unsigned",  32'h4F000000, 0, 0, 0, 32'h80000000, 3'b000);
  endtask

  task automatic t_uneg;
    conv("R8 -1.0 unsigned",   32'hBF800000, 0, 0, 0, 32'h00000000, 3'b100);
    conv("R8 -0.75 unsigned",  32'hBF400000, 0, 0, 0, 32'h00000000, 3'b100);
    conv("R8 -0.5 unsigned",   32'hBF000000, 0, 0, 0, 32'h00000000, 3'b010);
  endtask

  task automatic t_small;
    conv("R9 0.25 near",          32'h3E800000, 1, 0, 0, 32'h00000000, 3'b010);
    conv("R9 0.25 +inf",          32'h3E800000, 0, 1, 0, 32'h00000001, 3'b010);
    conv("R9 -0.25 -inf signed",  32'hBE800000, 1, 2, 0, 32'hFFFFFFFF, 3'b010);
    conv("R9 -0.25 -inf unsigned",32'hBE800000, 0, 2, 0, 32'h00000000, 3'b110);
    conv("R9 -0.25 +inf signed",  32'hBE800000, 1, 1, 0, 32'h00000000, 3'b010);
  endtask

  task automatic t_denorm;
    conv("R10 denorm near",  32'h00000001, 1, 0, 0, 32'h00000000, 3'b011);
    conv("R10 denorm +inf",  32'h00400000, 0, 1, 0, 32'h00000001, 3'b011);
    conv("R10 -denorm -inf", 32'h80000005, 1, 2, 0, 32'hFFFFFFFF, 3'b011);
  endtask

  task automatic t_zero;
    conv("R11 +0 +inf", 32'h00000000, 0, 1, 0, 32'h00000000, 3'b000);
    conv("R11 -0 -inf", 32'h80000000, 1, 2, 0, 32'h00000000, 3'b000);
  endtask

  task automatic t_hold;
    conv("R2 setup 3.5", 32'h40600000, 1, 0, 0, 32'h00000004, 3'b010);
    in_data = 32'h7FC00000; is_signed = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check("R2 idle hold", out_int, 32'h00000004, {out_invalid, out_inexact, out_denorm}, 3'b010);
    total++;
    if (out_valid !== 1'b0) begin bad++; $display("FAIL R2 idle: actual out_valid=%b expected 0", out_valid); end
  endtask

  initial begin
    t_reset();
    t_nearest();
    t_directed();
    t_trunc();
    t_nan();
    t_huge();
    t_clamp();
    t_uneg();
    t_small();
    t_denorm();
    t_zero();
    t_hold();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule